// File: doc/BRIEF.md
# Write-Combining Buffer Pool Controller

This block manages a small pool of line-sized buffers shared between two kinds of user. Load, store-miss and prefetch logic borrows a buffer as a line-fill buffer through a request/grant pair and hands it back with a release. Streaming stores arrive as partial lines with a per-byte enable mask. They are gathered into write-combining buffers, and every buffer in the pool may be combining a different line at the same time. Each buffer keeps its line address, its data and a dirty bit per byte.

Buffers leave the pool for the bus as whole-line writes. A buffer goes out when all of its bytes are dirty. It also goes out when a newcomer needs room and the pool is full; the victim is then the oldest combining buffer. A fence drains every open combining buffer. Writes that are ready to leave are issued oldest first, one per cycle while the bus accepts them.

The bus payload is a line address, a byte-enable mask and a line of data. The bus write handshake is valid/ready: a presented write stays unchanged until it is taken.

Top module: `wc_combine_ctrl`

## Requirements
- R1: After reset every buffer is free. `bus_valid_o` and `fence_ack_o` are low, `wr_ready_o` is high, and a fill request is granted at once with id 0.
- R2: A write whose line address matches an open combining buffer merges into it without allocating. Only bytes whose enable bit is set are replaced, and the later write wins on an overlapping byte. The bus mask is the union of all merged masks. A write must carry at least one enabled byte.
- R3: A buffer whose 32 bytes have all become dirty is presented on the bus in the cycle after the completing write is accepted. Partly dirty buffers stay in the pool while no other cause applies.
- R4: When a write finds no matching buffer, or a fill request arrives, and no buffer is free, the oldest combining buffer in allocation order is evicted even though it is partly dirty. The write or the fill is held (`wr_ready_o` or `fill_gnt_o` low) until that buffer has been taken by the bus.
- R5: All four buffers can hold open combining lines at once with no bus activity.
- R6: A presented bus write holds its address, mask and data while `bus_ready_i` is low. Pending evictions go out oldest first on consecutive cycles, with no idle cycle between them.
- R7: A pulse on `fence_i` evicts every open combining buffer and holds `wr_ready_o` low until the drain is complete. `fence_ack_o` then pulses for one cycle.
- R8: A fill request takes the lowest-numbered free buffer and reports its index on `fill_id_o`. `fill_rel_i` with that index returns the buffer to the free pool.
- R9: Bus payload layout: `bus_addr_o` is the line address. Bit k of `bus_be_o` and bits 8k+7:8k of `bus_data_o` describe byte k of the line. An eviction never carries an empty mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Streaming store present |
| wr_ready_o | output | 1 | Store accepted this cycle |
| wr_addr_i | input | 26 | Line address of the store |
| wr_be_i | input | 32 | Byte enables, bit k = byte k |
| wr_data_i | input | 256 | Store data, byte k at bits 8k+7:8k |
| fill_req_i | input | 1 | Request a buffer for a line fill |
| fill_gnt_o | output | 1 | Fill request granted this cycle |
| fill_id_o | output | 2 | Index of the granted buffer |
| fill_rel_i | input | 1 | Return a fill buffer |
| fill_rel_id_i | input | 2 | Index of the returned buffer |
| fence_i | input | 1 | Drain all combining buffers (pulse) |
| fence_ack_o | output | 1 | Drain complete (one-cycle pulse) |
| bus_valid_o | output | 1 | Line write presented |
| bus_ready_i | input | 1 | Bus takes the write this cycle |
| bus_addr_o | output | 26 | Line address of the write |
| bus_be_o | output | 32 | Dirty-byte mask of the write |
| bus_data_o | output | 256 | Line data of the write |

## Verification
The bound checker watches several rules on every cycle. A stalled bus write must hold still. No cycle may go idle between queued evictions. A fence must block stores. The acknowledge must be a single pulse. A fill refused on a full pool must start an eviction in the next cycle. Other properties depend on the history of the stream of writes, and only the bench scenarios can show them: merge contents and byte precedence, the choice of the oldest victim, the lowest-index fill grant and its release, and eviction on a full mask. The random phase drives many writes over a few lines against a stalling bus and then fences. Every line image collected from the bus must equal the bench's merge of all accepted writes.

// File: rtl/wc_pkg.sv
package wc_pkg;
  typedef enum logic [1:0] {
    BUF_FREE  = 2'd0,
    BUF_WC    = 2'd1,
    BUF_EVICT = 2'd2,
    BUF_FILL  = 2'd3
  } buf_state_e;
endpackage

// File: rtl/wc_pick_first.sv
module wc_pick_first #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) gnt_o = '0;
      if (req_i[i]) gnt_o[i] = 1'b1;
    end
  end
endmodule

// File: rtl/wc_age_tracker.sv
// Age matrix over combining allocations; older_q[i][j] = buffer i allocated before j.
module wc_age_tracker #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] alloc_oh_i,
  input  logic [N-1:0] cand_a_i,
  input  logic [N-1:0] cand_b_i,
  output logic [N-1:0] oldest_a_o,
  output logic [N-1:0] oldest_b_o
);
  logic [N-1:0][N-1:0] older_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          older_q[i][j] <= (i < j);
    end else begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (alloc_oh_i[i]) older_q[i][j] <= 1'b0;
          else if (alloc_oh_i[j]) older_q[i][j] <= 1'b1;
    end
  end

  always_comb begin
    oldest_a_o = cand_a_i;
    oldest_b_o = cand_b_i;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (j != i && older_q[j][i]) begin
          if (cand_a_i[j]) oldest_a_o[i] = 1'b0;
          if (cand_b_i[j]) oldest_b_o[i] = 1'b0;
        end
  end
endmodule

// File: rtl/wc_line_buf.sv
module wc_line_buf #(
  parameter int LINE_BYTES = 32,
  parameter int ADDR_W     = 26,
  localparam int DATA_W    = LINE_BYTES * 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic                  merge_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [LINE_BYTES-1:0] be_i,
  input  logic [DATA_W-1:0]     data_i,
  output logic [ADDR_W-1:0]     addr_o,
  output logic [LINE_BYTES-1:0] dirty_o,
  output logic [DATA_W-1:0]     data_o,
  output logic                  full_merge_o
);
  logic [ADDR_W-1:0]     addr_q;
  logic [LINE_BYTES-1:0] dirty_q;
  logic [DATA_W-1:0]     data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      dirty_q <= '0;
      data_q  <= '0;
    end else if (load_i) begin
      addr_q  <= addr_i;
      dirty_q <= be_i;
      for (int b = 0; b < LINE_BYTES; b++)
        data_q[8*b +: 8] <= be_i[b] ? data_i[8*b +: 8] : 8'h00;
    end else if (merge_i) begin
      dirty_q <= dirty_q | be_i;
      for (int b = 0; b < LINE_BYTES; b++)
        if (be_i[b]) data_q[8*b +: 8] <= data_i[8*b +: 8];
    end
  end

  assign addr_o       = addr_q;
  assign dirty_o      = dirty_q;
  assign data_o       = data_q;
  assign full_merge_o = &(dirty_q | be_i);
endmodule

// File: rtl/wc_combine_ctrl.sv
module wc_combine_ctrl
  import wc_pkg::*;
#(
  parameter int N_BUF      = 4,
  parameter int LINE_BYTES = 32,
  parameter int ADDR_W     = 26,
  localparam int DATA_W    = LINE_BYTES * 8,
  localparam int IDX_W     = (N_BUF > 1) ? $clog2(N_BUF) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_valid_i,
  output logic                  wr_ready_o,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [LINE_BYTES-1:0] wr_be_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic                  fill_req_i,
  output logic                  fill_gnt_o,
  output logic [IDX_W-1:0]      fill_id_o,
  input  logic                  fill_rel_i,
  input  logic [IDX_W-1:0]      fill_rel_id_i,
  input  logic                  fence_i,
  output logic                  fence_ack_o,
  output logic                  bus_valid_o,
  input  logic                  bus_ready_i,
  output logic [ADDR_W-1:0]     bus_addr_o,
  output logic [LINE_BYTES-1:0] bus_be_o,
  output logic [DATA_W-1:0]     bus_data_o
);
  buf_state_e state_q [N_BUF];
  buf_state_e state_d [N_BUF];

  logic [N_BUF-1:0] free_m, wc_m, ev_m, hit_m, full_m;
  logic [N_BUF-1:0] fill_pick, free_after, wr_pick, wr_alloc, wr_merge;
  logic [N_BUF-1:0] oldest_wc, oldest_ev, victim, bus_sel, held_q;
  logic [ADDR_W-1:0]     buf_addr  [N_BUF];
  logic [LINE_BYTES-1:0] buf_dirty [N_BUF];
  logic [DATA_W-1:0]     buf_data  [N_BUF];
  logic hit_any, wr_room, wr_fire, wr_blk, fill_blk, force_evict, bus_fire;
  logic fence_busy_q;

  always_comb begin
    for (int i = 0; i < N_BUF; i++) begin
      free_m[i] = (state_q[i] == BUF_FREE);
      wc_m[i]   = (state_q[i] == BUF_WC);
      ev_m[i]   = (state_q[i] == BUF_EVICT);
      hit_m[i]  = wc_m[i] && (buf_addr[i] == wr_addr_i);
    end
  end

  wc_pick_first #(.N(N_BUF)) u_pick_fill (.req_i(free_m),     .gnt_o(fill_pick));
  wc_pick_first #(.N(N_BUF)) u_pick_wr   (.req_i(free_after), .gnt_o(wr_pick));

  assign hit_any    = |hit_m;
  assign fill_gnt_o = fill_req_i & (|free_m);
  assign free_after = free_m & ~(fill_gnt_o ? fill_pick : '0);
  assign wr_room    = |free_after;
  assign wr_ready_o = ~fence_busy_q & ~fence_i & (hit_any | wr_room);
  assign wr_fire    = wr_valid_i & wr_ready_o;
  assign wr_alloc   = (wr_fire & ~hit_any) ? wr_pick : '0;
  assign wr_merge   = wr_fire ? hit_m : '0;

  // Pool exhausted: push the oldest combining line out, one at a time.
  assign wr_blk      = wr_valid_i & ~fence_busy_q & ~fence_i & ~hit_any & ~wr_room;
  assign fill_blk    = fill_req_i & ~(|free_m);
  assign force_evict = (wr_blk | fill_blk) & ~(|ev_m);
  assign victim      = force_evict ? oldest_wc : '0;

  wc_age_tracker #(.N(N_BUF)) u_age (
    .clk_i, .rst_ni,
    .alloc_oh_i (wr_alloc),
    .cand_a_i   (wc_m),
    .cand_b_i   (ev_m),
    .oldest_a_o (oldest_wc),
    .oldest_b_o (oldest_ev)
  );

  for (genvar g = 0; g < N_BUF; g++) begin : g_buf
    wc_line_buf #(.LINE_BYTES(LINE_BYTES), .ADDR_W(ADDR_W)) u_line (
      .clk_i, .rst_ni,
      .load_i       (wr_alloc[g]),
      .merge_i      (wr_merge[g]),
      .addr_i       (wr_addr_i),
      .be_i         (wr_be_i),
      .data_i       (wr_data_i),
      .addr_o       (buf_addr[g]),
      .dirty_o      (buf_dirty[g]),
      .data_o       (buf_data[g]),
      .full_merge_o (full_m[g])
    );
  end

  // A stalled write keeps its slot on the bus even if an older line turns up.
  assign bus_sel     = (|held_q) ? held_q : oldest_ev;
  assign bus_valid_o = |ev_m;
  assign bus_fire    = bus_valid_o & bus_ready_i;

  always_comb begin
    bus_addr_o = '0;
    bus_be_o   = '0;
    bus_data_o = '0;
    fill_id_o  = '0;
    for (int i = 0; i < N_BUF; i++) begin
      if (bus_sel[i]) begin
        bus_addr_o = bus_addr_o | buf_addr[i];
        bus_be_o   = bus_be_o   | buf_dirty[i];
        bus_data_o = bus_data_o | buf_data[i];
      end
      if (fill_pick[i]) fill_id_o = IDX_W'(i);
    end
  end

  assign fence_ack_o = fence_busy_q & ~(|wc_m) & ~(|ev_m);

  always_comb begin
    for (int i = 0; i < N_BUF; i++) begin
      state_d[i] = state_q[i];
      if (fill_rel_i && fill_rel_id_i == IDX_W'(i) && state_q[i] == BUF_FILL)
        state_d[i] = BUF_FREE;
      if (bus_fire && bus_sel[i]) state_d[i] = BUF_FREE;
      if (fence_i && state_q[i] == BUF_WC) state_d[i] = BUF_EVICT;
      if (victim[i]) state_d[i] = BUF_EVICT;
      if (wr_merge[i] && full_m[i]) state_d[i] = BUF_EVICT;
      if (wr_alloc[i]) state_d[i] = (&wr_be_i) ? BUF_EVICT : BUF_WC;
      if (fill_gnt_o && fill_pick[i]) state_d[i] = BUF_FILL;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_BUF; i++) state_q[i] <= BUF_FREE;
      held_q       <= '0;
      fence_busy_q <= 1'b0;
    end else begin
      for (int i = 0; i < N_BUF; i++) state_q[i] <= state_d[i];
      held_q <= (bus_valid_o && !bus_ready_i) ? bus_sel : '0;
      if (fence_i) fence_busy_q <= 1'b1;
      else if (fence_ack_o) fence_busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wc_combine_ctrl_chk.sv
module wc_combine_ctrl_chk #(
  parameter int N_BUF      = 4,
  parameter int LINE_BYTES = 32,
  parameter int ADDR_W     = 26
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  bus_valid_o,
  input logic                  bus_ready_i,
  input logic [ADDR_W-1:0]     bus_addr_o,
  input logic [LINE_BYTES-1:0] bus_be_o,
  input logic                  wr_ready_o,
  input logic                  fence_i,
  input logic                  fence_busy_q,
  input logic                  fence_ack_o,
  input logic                  fill_req_i,
  input logic                  fill_gnt_o,
  input logic [N_BUF-1:0]      wc_m,
  input logic [N_BUF-1:0]      ev_m
);
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && !bus_ready_i |=> bus_valid_o && $stable(bus_addr_o) && $stable(bus_be_o));

  p_no_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && bus_ready_i && $countones(ev_m) > 1 |=> bus_valid_o);

  p_nonempty_be_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> bus_be_o != '0);

  p_fence_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fence_busy_q |-> !wr_ready_o);

  p_ack_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fence_ack_o && !fence_i |=> !fence_ack_o);

  p_fill_forces_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_i && !fill_gnt_o && ev_m == '0 && wc_m != '0 |=> ev_m != '0);
endmodule

bind wc_combine_ctrl wc_combine_ctrl_chk #(
  .N_BUF(N_BUF), .LINE_BYTES(LINE_BYTES), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_valid_o  (bus_valid_o),
  .bus_ready_i  (bus_ready_i),
  .bus_addr_o   (bus_addr_o),
  .bus_be_o     (bus_be_o),
  .wr_ready_o   (wr_ready_o),
  .fence_i      (fence_i),
  .fence_busy_q (fence_busy_q),
  .fence_ack_o  (fence_ack_o),
  .fill_req_i   (fill_req_i),
  .fill_gnt_o   (fill_gnt_o),
  .wc_m         (wc_m),
  .ev_m         (ev_m)
);

// File: tb/wc_combine_ctrl_test.sv
`timescale 1ns/1ps
module wc_combine_ctrl_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_valid = 0, fill_req = 0, fill_rel = 0, fence = 0, bus_ready = 0;
  logic [25:0] wr_addr = '0;
  logic [31:0] wr_be = '0;
  logic [255:0] wr_data = '0;
  logic [1:0] fill_rel_id = '0;
  logic wr_ready_o, fill_gnt_o, fence_ack_o, bus_valid_o;
  logic [1:0] fill_id_o;
  logic [25:0] bus_addr_o;
  logic [31:0] bus_be_o;
  logic [255:0] bus_data_o;

  int n_tests = 0, n_fail = 0;
  logic [7:0] exp_mem [8][32];
  logic [7:0] act_mem [8][32];

  always #2.5 clk = ~clk;

  wc_combine_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready_o), .wr_addr_i(wr_addr),
    .wr_be_i(wr_be), .wr_data_i(wr_data),
    .fill_req_i(fill_req), .fill_gnt_o(fill_gnt_o), .fill_id_o(fill_id_o),
    .fill_rel_i(fill_rel), .fill_rel_id_i(fill_rel_id),
    .fence_i(fence), .fence_ack_o(fence_ack_o),
    .bus_valid_o(bus_valid_o), .bus_ready_i(bus_ready), .bus_addr_o(bus_addr_o),
    .bus_be_o(bus_be_o), .bus_data_o(bus_data_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [255:0] pat(input logic [7:0] base);
    logic [255:0] d;
    for (int k = 0; k < 32; k++) d[8*k +: 8] = base + 8'(k);
    return d;
  endfunction

  function automatic logic [255:0] merged_t2();
    logic [255:0] d;
    for (int k = 0; k < 32; k++)
      d[8*k +: 8] = (k < 3) ? 8'(k) : (k < 8) ? 8'(8'hA0 + k) : 8'(8'h40 + k);
    return d;
  endfunction

  // Bus monitor: transfer happens at the posedge after this sample.
  always @(negedge clk) begin
    if (rst_ni && bus_valid_o && bus_ready) begin
      chk(bus_be_o != '0, "R9", "empty eviction mask", 256'(bus_be_o), 256'h1);
      if (bus_addr_o >= 26'd16 && bus_addr_o < 26'd24)
        for (int k = 0; k < 32; k++)
          if (bus_be_o[k]) act_mem[bus_addr_o - 26'd16][k] = bus_data_o[8*k +: 8];
    end
  end

  task automatic wr(input logic [25:0] a, input logic [31:0] be, input logic [255:0] d);
    @(posedge clk); #1;
    wr_valid = 1; wr_addr = a; wr_be = be; wr_data = d;
    do @(negedge clk); while (!wr_ready_o);
    @(posedge clk); #1;
    wr_valid = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "watchdog", "run hung", 0, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int l = 0; l < 8; l++)
      for (int k = 0; k < 32; k++) begin exp_mem[l][k] = 0; act_mem[l][k] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;

    // R1: reset state
    @(negedge clk);
    chk(!bus_valid_o, "R1", "bus_valid after reset", 256'(bus_valid_o), 0);
    chk(wr_ready_o, "R1", "wr_ready after reset", 256'(wr_ready_o), 1);
    chk(!fence_ack_o, "R1", "fence_ack after reset", 256'(fence_ack_o), 0);
    fill_req = 1; #0.5;
    chk(fill_gnt_o && fill_id_o == 0, "R1", "fill grant after reset", 256'({fill_gnt_o, fill_id_o}), 256'h4);
    fill_req = 0;

    // R2/R3/R9: merge with overlap, then complete the line
    wr(26'd5, 32'h0000_000F, pat(8'h00));
    wr(26'd5, 32'h0000_00F8, pat(8'hA0));
    @(negedge clk);
    chk(!bus_valid_o, "R2", "partial line must stay", 256'(bus_valid_o), 0);
    wr(26'd5, 32'hFFFF_FF00, pat(8'h40));
    @(negedge clk);
    chk(bus_valid_o, "R3", "full line presented", 256'(bus_valid_o), 1);
    chk(bus_addr_o == 26'd5, "R9", "bus address", 256'(bus_addr_o), 5);
    chk(bus_be_o == 32'hFFFF_FFFF, "R2", "mask union", 256'(bus_be_o), 256'hFFFF_FFFF);
    chk(bus_data_o == merged_t2(), "R2", "merged data", bus_data_o, merged_t2());
    @(posedge clk); #1 bus_ready = 1;
    @(posedge clk); #1 bus_ready = 0;
    @(negedge clk);
    chk(!bus_valid_o, "R3", "buffer freed after transfer", 256'(bus_valid_o), 0);

    // R5: four lines open together
    bus_ready = 1;
    wr(26'd10, 32'h1, pat(8'h10));
    wr(26'd11, 32'h2, pat(8'h20));
    wr(26'd12, 32'h4, pat(8'h30));
    wr(26'd13, 32'h8, pat(8'h50));
    wr(26'd10, 32'h10, pat(8'h60));
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(!bus_valid_o, "R5", "four open lines, no eviction", 256'(bus_valid_o), 0);
    end

    // R4: fifth line evicts oldest (line 10)
    @(posedge clk); #1;
    bus_ready = 0;
    wr_valid = 1; wr_addr = 26'd14; wr_be = 32'h1; wr_data = pat(8'h70);
    @(negedge clk);
    chk(!wr_ready_o, "R4", "write held on full pool", 256'(wr_ready_o), 0);
    @(negedge clk);
    chk(bus_valid_o && bus_addr_o == 26'd10, "R4", "victim is oldest line", 256'(bus_addr_o), 10);
    chk(bus_be_o == 32'h11, "R4", "victim mask", 256'(bus_be_o), 256'h11);
    @(posedge clk); #1 bus_ready = 1;
    do @(negedge clk); while (!wr_ready_o);
    @(posedge clk); #1 wr_valid = 0; bus_ready = 0;

    // R4/R8: fill on full pool evicts line 11 (buffer 1)
    fill_req = 1;
    @(negedge clk);
    chk(!fill_gnt_o, "R4", "fill held on full pool", 256'(fill_gnt_o), 0);
    @(negedge clk);
    chk(bus_valid_o && bus_addr_o == 26'd11, "R4", "fill-forced victim", 256'(bus_addr_o), 11);
    @(posedge clk); #1 bus_ready = 1;
    do @(negedge clk); while (!fill_gnt_o);
    chk(fill_id_o == 2'd1, "R8", "fill takes freed buffer", 256'(fill_id_o), 1);
    @(posedge clk); #1 fill_req = 0; bus_ready = 0;

    // R7/R6: fence drains 12,13,14 back to back
    fence = 1;
    @(posedge clk); #1 fence = 0;
    @(negedge clk);
    chk(!wr_ready_o, "R7", "stores blocked during fence", 256'(wr_ready_o), 0);
    chk(!fence_ack_o, "R7", "no early ack", 256'(fence_ack_o), 0);
    chk(bus_valid_o && bus_addr_o == 26'd12, "R6", "first drained line", 256'(bus_addr_o), 12);
    @(posedge clk); #1 bus_ready = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(bus_valid_o && bus_addr_o == 26'd12 + 26'(k), "R6", "back-to-back order",
          256'({bus_valid_o, bus_addr_o}), 256'({1'b1, 26'd12 + 26'(k)}));
    end
    @(negedge clk);
    chk(!bus_valid_o && fence_ack_o, "R7", "drained and acknowledged",
        256'({bus_valid_o, fence_ack_o}), 256'h1);
    @(negedge clk);
    chk(!fence_ack_o, "R7", "ack is a pulse", 256'(fence_ack_o), 0);
    bus_ready = 0;

    // R8: lowest free grant and release
    @(posedge clk); #1 fill_req = 1;
    @(negedge clk);
    chk(fill_gnt_o && fill_id_o == 2'd0, "R8", "lowest free id 0", 256'(fill_id_o), 0);
    @(posedge clk); #1;
    @(negedge clk);
    chk(fill_gnt_o && fill_id_o == 2'd2, "R8", "next free id 2", 256'(fill_id_o), 2);
    @(posedge clk); #1 fill_req = 0; fill_rel = 1; fill_rel_id = 2'd1;
    @(posedge clk); #1 fill_rel = 0; fill_req = 1;
    @(negedge clk);
    chk(fill_gnt_o && fill_id_o == 2'd1, "R8", "released buffer reused", 256'(fill_id_o), 1);
    @(posedge clk); #1 fill_req = 0;
    for (int k = 0; k < 3; k++) begin
      fill_rel = 1; fill_rel_id = 2'(k);
      @(posedge clk); #1;
    end
    fill_rel = 0;

    // Random phase: R2/R6/R9 line image check
    begin
      bit acc = 0, fgot = 0, hold = 0;
      int hold_cnt = 0;
      logic [1:0] hold_id = 0;
      for (int cyc = 0; cyc < 4000; cyc++) begin
        @(posedge clk); #1;
        if (acc) begin wr_valid = 0; acc = 0; end
        if (fgot) begin fill_req = 0; fgot = 0; end
        fill_rel = 0;
        if (hold) begin
          if (hold_cnt == 0) begin fill_rel = 1; fill_rel_id = hold_id; hold = 0; end
          else hold_cnt--;
        end
        if (!wr_valid && ($urandom % 10) < 6) begin
          logic [31:0] be;
          case ($urandom_range(0, 3))
            0: be = 32'hFFFF_FFFF;
            1: be = $urandom & $urandom;
            2: be = 32'hFF << (8 * $urandom_range(0, 3));
            default: be = $urandom;
          endcase
          if (be == 0) be = 32'h1;
          wr_valid = 1; wr_addr = 26'd16 + 26'($urandom_range(0, 7)); wr_be = be;
          wr_data = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        end
        bus_ready = ($urandom % 10) < 7;
        if (!hold && !fill_req && ($urandom % 25) == 0) fill_req = 1;
        @(negedge clk);
        if (wr_valid && wr_ready_o) begin
          acc = 1;
          for (int k = 0; k < 32; k++)
            if (wr_be[k]) exp_mem[wr_addr - 26'd16][k] = wr_data[8*k +: 8];
        end
        if (fill_req && fill_gnt_o) begin
          fgot = 1; hold = 1; hold_id = fill_id_o; hold_cnt = $urandom_range(1, 8);
        end
      end
      @(posedge clk); #1;
      wr_valid = 0; fill_req = 0;
      fill_rel = hold; fill_rel_id = hold_id;
      @(posedge clk); #1 fill_rel = 0; fence = 1; bus_ready = 1;
      @(posedge clk); #1 fence = 0;
      do @(negedge clk); while (!fence_ack_o);
    end
    for (int l = 0; l < 8; l++) begin
      logic [255:0] e, a;
      for (int k = 0; k < 32; k++) begin e[8*k +: 8] = exp_mem[l][k]; a[8*k +: 8] = act_mem[l][k]; end
      chk(a == e, "R2", $sformatf("line %0d image after random stream (R9 layout)", 16 + l), a, e);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule